// File: doc/BRIEF.md
# EEPROM Page Write and Completion Poll Sequencer

This block is a bus master for a byte-wide parallel EEPROM. On a start request it writes one page of 1 to 128 bytes, taken in order from a small host-side buffer, to a page selected by the upper address bits. Optionally it first issues the three-write unlock prefix that opens a write window on protected devices. It times every strobe in whole clock cycles, derived from nanosecond parameters and the clock period.

After the last byte load the block does not wait a fixed worst-case time. It runs ordinary read cycles against the last address written and decides completion from the status bits. In data-poll mode it compares the top data bit with the value just written. In toggle mode it compares bit 6 across two back-to-back reads. It then pulses done, or it pulses an error flag if polling outlasts the worst-case programming time plus a margin.

The host holds data in a buffer that the block indexes through `buf_idx_o`. The buffer returns the entry on `buf_data_i` in the same cycle.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, chip enable, write enable and output enable are high (inactive), the data bus is not driven, and busy, done and error are low.
- R2: Data byte k (k = 0 to count-1) is written to address {page_i, k[6:0]} with buffer entry k, in ascending order, exactly count times. Address bits 14 to 7 equal page_i for every data byte.
- R3: When unlock_i is high at start, three writes come first, in this order: data 0xAA to 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555. When unlock_i is low, no prefix is sent.
- R4: Write enable stays low for at least ceil(T_WP_NS/CLK_NS) cycles (3 at defaults). Address and data stay constant while it is low.
- R5: Consecutive write-enable falling edges of one page are exactly 1+ceil(T_SETUP_NS/CLK_NS)+ceil(T_WP_NS/CLK_NS)+ceil(T_WPH_NS/CLK_NS) cycles apart (10 at defaults). This is far inside the T_BLC_NS byte-load window.
- R6: Polling reads hold chip enable and output enable low and write enable high, and leave the data bus undriven. Write enable and output enable are never low together.
- R7: With poll_mode_i = 0 (data poll), completion is declared on the first read of the last address whose bit 7 equals bit 7 of the last data written.
- R8: With poll_mode_i = 1 (toggle), completion is declared when two consecutive reads return the same bit 6.
- R9: done_o is a single-cycle pulse, raised only after the device has stopped programming, and busy_o falls with it.
- R10: If polling has run for ceil((TWC_NS+TMO_MARGIN_NS)/CLK_NS) cycles without completion, err_o pulses for one cycle instead of done_o and the block returns to idle.
- R11: start_i is ignored while busy_o is high; no further writes occur after the accepted page completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled while idle |
| unlock_i | input | 1 | Send unlock prefix before data |
| poll_mode_i | input | 1 | 0 = data poll on bit 7, 1 = toggle poll on bit 6 |
| page_i | input | 8 | Page number, address bits 14 to 7 |
| count_i | input | 8 | Number of data bytes, 1 to 128 |
| buf_idx_o | output | 7 | Index of the buffer entry being fetched |
| buf_data_i | input | 8 | Buffer entry at buf_idx_o |
| mem_ce_no | output | 1 | Memory chip enable, active low |
| mem_we_no | output | 1 | Memory write enable, active low |
| mem_oe_no | output | 1 | Memory output enable, active low |
| mem_addr_o | output | 15 | Memory address |
| mem_dq_o | output | 8 | Write data to memory |
| mem_dq_oe_o | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 8 | Read data from memory |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse on completion |
| err_o | output | 1 | One-cycle pulse on polling timeout |

## Verification
Assertions check, on every cycle, the rules that hold regardless of the device response. These cover the exclusion of write and output enable, bus release during reads, stable address and data under a write pulse, the minimum pulse width, a constant page on data loads, byte-load spacing under the window, that toggle completion needs a prior read, and that done and error never coincide. Only the bench's device model can show the rest. That covers the order and content of the written bytes and the prefix, and that completion comes after the device turns ready and within a few read cycles of it, in both poll modes. It also covers the timeout latency, and that a start during a page leaves no trace.

// File: rtl/epw_pkg.sv
package epw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_READ,
    ST_GAP
  } epw_state_e;

  localparam logic POLL_DATA   = 1'b0;
  localparam logic POLL_TOGGLE = 1'b1;

  localparam logic [15:0] UNLK_ADDR_HI = 16'h5555;
  localparam logic [15:0] UNLK_ADDR_LO = 16'h2AAA;
  localparam logic [7:0]  UNLK_D0      = 8'hAA;
  localparam logic [7:0]  UNLK_D1      = 8'h55;
  localparam logic [7:0]  UNLK_D2      = 8'hA0;

  // ceil(ns / clk_ns), never less than one cycle
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/epw_phase_timer.sv
module epw_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  assert_timer_idle_stays_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o);

endmodule

// File: rtl/epw_watchdog.sv
module epw_watchdog #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic expired_o
);

  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign expired_o = (cnt_q == CW'(LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clear_i)             cnt_q <= '0;
    else if (run_i && !expired_o) cnt_q <= cnt_q + 1'b1;
  end

  assert_wd_no_wrap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && !clear_i) |=> expired_o);

endmodule

// File: rtl/epw_poll_check.sv
module epw_poll_check #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              sample_i,
  input  logic              mode_i,
  input  logic [DATA_W-1:0] dq_i,
  input  logic              ref_msb_i,
  output logic              ready_o
);

  import epw_pkg::*;

  logic have_q, prev_q, ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q  <= 1'b0;
      prev_q  <= 1'b0;
      ready_q <= 1'b0;
    end else if (clear_i) begin
      have_q  <= 1'b0;
      prev_q  <= 1'b0;
      ready_q <= 1'b0;
    end else if (sample_i) begin
      if (mode_i == POLL_DATA) begin
        ready_q <= (dq_i[DATA_W-1] == ref_msb_i);
      end else begin
        if (have_q) ready_q <= (dq_i[DATA_W-2] == prev_q);
        prev_q <= dq_i[DATA_W-2];
        have_q <= 1'b1;
      end
    end
  end

  assign ready_o = ready_q;

  // toggle completion needs a read before the deciding one
  assert_toggle_two_reads_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ready_o) && mode_i == POLL_TOGGLE) |-> $past(have_q));

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import epw_pkg::*;
#(
  parameter int unsigned ADDR_W        = 15,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned PAGE_BYTES    = 128,
  parameter int unsigned CLK_NS        = 20,
  parameter int unsigned T_SETUP_NS    = 50,
  parameter int unsigned T_WP_NS       = 50,
  parameter int unsigned T_WPH_NS      = 50,
  parameter int unsigned T_ACC_NS      = 150,
  parameter int unsigned T_OFF_NS      = 50,
  parameter int unsigned T_BLC_NS      = 100_000,
  parameter int unsigned TWC_NS        = 10_000_000,
  parameter int unsigned TMO_MARGIN_NS = 1_000_000
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   start_i,
  input  logic                                   unlock_i,
  input  logic                                   poll_mode_i,
  input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0]   page_i,
  input  logic [$clog2(PAGE_BYTES+1)-1:0]        count_i,
  output logic [$clog2(PAGE_BYTES)-1:0]          buf_idx_o,
  input  logic [DATA_W-1:0]                      buf_data_i,
  output logic                                   mem_ce_no,
  output logic                                   mem_we_no,
  output logic                                   mem_oe_no,
  output logic [ADDR_W-1:0]                      mem_addr_o,
  output logic [DATA_W-1:0]                      mem_dq_o,
  output logic                                   mem_dq_oe_o,
  input  logic [DATA_W-1:0]                      mem_dq_i,
  output logic                                   busy_o,
  output logic                                   done_o,
  output logic                                   err_o
);

  localparam int unsigned OFF_W     = $clog2(PAGE_BYTES);
  localparam int unsigned PAGE_W    = ADDR_W - OFF_W;
  localparam int unsigned CNT_W     = $clog2(PAGE_BYTES + 1);
  localparam int unsigned SETUP_CYC = ns_to_cyc(T_SETUP_NS, CLK_NS);
  localparam int unsigned PULSE_CYC = ns_to_cyc(T_WP_NS, CLK_NS);
  localparam int unsigned HOLD_CYC  = ns_to_cyc(T_WPH_NS, CLK_NS);
  localparam int unsigned READ_CYC  = ns_to_cyc(T_ACC_NS, CLK_NS);
  localparam int unsigned GAP_CYC   = ns_to_cyc(T_OFF_NS, CLK_NS);
  localparam int unsigned BLC_CYC   = ns_to_cyc(T_BLC_NS, CLK_NS);
  localparam int unsigned TMO_CYC   = ns_to_cyc(TWC_NS + TMO_MARGIN_NS, CLK_NS);
  localparam int unsigned TMR_MAX   = max2(max2(SETUP_CYC, PULSE_CYC),
                                           max2(HOLD_CYC, max2(READ_CYC, GAP_CYC)));
  localparam int unsigned TMR_W     = $clog2(TMR_MAX + 1);
  localparam int unsigned LOW_W     = $clog2(PULSE_CYC + 2);
  localparam int unsigned GAPC_W    = $clog2(BLC_CYC + 1);

  epw_state_e             state_q, state_d;
  logic [PAGE_W-1:0]      page_q;
  logic [CNT_W-1:0]       left_q;
  logic [1:0]             pfx_q;
  logic [OFF_W-1:0]       idx_q;
  logic [ADDR_W-1:0]      addr_q;
  logic [DATA_W-1:0]      data_q;
  logic                   mode_q, is_data_q;
  logic                   done_q, err_q, done_d, err_d;
  logic                   tmr_load, tmr_zero;
  logic [TMR_W-1:0]       tmr_val;
  logic                   poll_ready, wd_expired, accept;

  assign accept = (state_q == ST_IDLE) && start_i;

  epw_phase_timer #(.CNT_W(TMR_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  epw_poll_check #(.DATA_W(DATA_W)) u_poll (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (accept),
    .sample_i  (state_q == ST_READ && tmr_zero),
    .mode_i    (mode_q),
    .dq_i      (mem_dq_i),
    .ref_msb_i (data_q[DATA_W-1]),
    .ready_o   (poll_ready)
  );

  epw_watchdog #(.LIMIT(TMO_CYC)) u_wd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (state_q == ST_IDLE),
    .run_i     (state_q == ST_READ || state_q == ST_GAP),
    .expired_o (wd_expired)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    done_d   = 1'b0;
    err_d    = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_LOAD;
      ST_LOAD: begin
        state_d  = ST_SETUP;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(SETUP_CYC - 1);
      end
      ST_SETUP: if (tmr_zero) begin
        state_d  = ST_PULSE;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(PULSE_CYC - 1);
      end
      ST_PULSE: if (tmr_zero) begin
        state_d  = ST_HOLD;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(HOLD_CYC - 1);
      end
      ST_HOLD: if (tmr_zero) begin
        if (pfx_q != '0 || left_q != '0) begin
          state_d = ST_LOAD;
        end else begin
          state_d  = ST_READ;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(READ_CYC - 1);
        end
      end
      ST_READ: begin
        if (wd_expired) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end else if (tmr_zero) begin
          state_d  = ST_GAP;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(GAP_CYC - 1);
        end
      end
      ST_GAP: begin
        if (tmr_zero && poll_ready) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else if (wd_expired) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end else if (tmr_zero) begin
          state_d  = ST_READ;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(READ_CYC - 1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      page_q    <= '0;
      left_q    <= '0;
      pfx_q     <= '0;
      idx_q     <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      mode_q    <= POLL_DATA;
      is_data_q <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
      if (accept) begin
        page_q <= page_i;
        left_q <= count_i;
        pfx_q  <= unlock_i ? 2'd3 : 2'd0;
        idx_q  <= '0;
        mode_q <= poll_mode_i;
      end else if (state_q == ST_LOAD) begin
        if (pfx_q != '0) begin
          is_data_q <= 1'b0;
          pfx_q     <= pfx_q - 1'b1;
          unique case (pfx_q)
            2'd3:    begin addr_q <= ADDR_W'(UNLK_ADDR_HI); data_q <= DATA_W'(UNLK_D0); end
            2'd2:    begin addr_q <= ADDR_W'(UNLK_ADDR_LO); data_q <= DATA_W'(UNLK_D1); end
            default: begin addr_q <= ADDR_W'(UNLK_ADDR_HI); data_q <= DATA_W'(UNLK_D2); end
          endcase
        end else begin
          is_data_q <= 1'b1;
          addr_q    <= {page_q, idx_q};
          data_q    <= buf_data_i;
          idx_q     <= idx_q + 1'b1;
          left_q    <= left_q - 1'b1;
        end
      end
    end
  end

  assign buf_idx_o   = idx_q;
  assign mem_ce_no   = (state_q == ST_IDLE);
  assign mem_we_no   = (state_q != ST_PULSE);
  assign mem_oe_no   = (state_q != ST_READ);
  assign mem_dq_oe_o = (state_q == ST_LOAD) || (state_q == ST_SETUP) ||
                       (state_q == ST_PULSE) || (state_q == ST_HOLD);
  assign mem_addr_o  = addr_q;
  assign mem_dq_o    = data_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;

  // checker support: width of the current write pulse, spacing of falls
  logic [LOW_W-1:0]  low_cnt_q;
  logic [GAPC_W-1:0] gap_cnt_q;
  logic              gap_vld_q, we_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt_q <= '0;
      gap_cnt_q <= '0;
      gap_vld_q <= 1'b0;
      we_prev_q <= 1'b1;
    end else begin
      we_prev_q <= mem_we_no;
      if (mem_we_no)                              low_cnt_q <= '0;
      else if (low_cnt_q != LOW_W'(PULSE_CYC + 1)) low_cnt_q <= low_cnt_q + 1'b1;
      if (state_q == ST_IDLE) begin
        gap_vld_q <= 1'b0;
        gap_cnt_q <= '0;
      end else if (we_prev_q && !mem_we_no) begin
        gap_vld_q <= 1'b1;
        gap_cnt_q <= GAPC_W'(1);
      end else if (gap_cnt_q != GAPC_W'(BLC_CYC)) begin
        gap_cnt_q <= gap_cnt_q + 1'b1;
      end
    end
  end

  assert_strobe_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_we_no && !mem_oe_no));

  assert_bus_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> (!mem_dq_oe_o && !mem_ce_no));

  assert_we_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_no && $past(!mem_we_no)) |-> ($stable(mem_addr_o) && $stable(mem_dq_o)));

  assert_we_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> (low_cnt_q >= LOW_W'(PULSE_CYC)));

  assert_page_fixed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_no && is_data_q) |-> (mem_addr_o[ADDR_W-1:OFF_W] == page_q));

  assert_load_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(mem_we_no) && gap_vld_q) |-> (gap_cnt_q < GAPC_W'(BLC_CYC)));

  assert_done_err_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  assert_start_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !$past(state_q == ST_IDLE)) |-> ($stable(page_q) && $stable(mode_q)));

endmodule

// File: tb/sim_eeprom_page_writer.sv
module sim_eeprom_page_writer;

  localparam int TWC_NS   = 20_000;
  localparam int MARG_NS  = 2_000;
  localparam int TMO_EXP  = (TWC_NS + MARG_NS + 19) / 20;  // 1100 cycles
  localparam int PW_MIN   = 3;                              // ceil(50/20)
  localparam int BYTE_PER = 1 + 3 + 3 + 3;                  // load+setup+pulse+hold
  localparam int NEVER    = 1_000_000_000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, unlock = 1'b0, pmode = 1'b0;
  logic [7:0]  page = '0, count = '0;
  logic [6:0]  buf_idx;
  logic [7:0]  buf_data;
  logic        ce_n, we_n, oe_n, dq_oe, busy, done, err;
  logic [14:0] addr;
  logic [7:0]  dq_out;
  logic [7:0]  dq_in = '0;

  logic [7:0]  buf_mem [0:127];
  assign buf_data = buf_mem[buf_idx];

  always #10 clk = ~clk;

  eeprom_page_writer #(.TWC_NS(TWC_NS), .TMO_MARGIN_NS(MARG_NS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .unlock_i(unlock),
    .poll_mode_i(pmode), .page_i(page), .count_i(count),
    .buf_idx_o(buf_idx), .buf_data_i(buf_data),
    .mem_ce_no(ce_n), .mem_we_no(we_n), .mem_oe_no(oe_n),
    .mem_addr_o(addr), .mem_dq_o(dq_out), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_in),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  int n_cmp = 0, n_bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // device model state
  logic [14:0] log_a [0:135];
  logic [7:0]  log_d [0:135];
  int log_n, rd_viol, stab_err, min_pw, max_gap, n_reads;
  int fall_cyc, last_fall, rise_cyc, ready_cyc, busy_len;
  bit have_fall, tog, prev_we = 1'b1, prev_oe = 1'b1;
  logic [14:0] fall_a;
  logic [7:0]  fall_d, last_d = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_we && !we_n) begin
        fall_a = addr; fall_d = dq_out; fall_cyc = cyc;
        if (have_fall && (cyc - last_fall) > max_gap) max_gap = cyc - last_fall;
        last_fall = cyc; have_fall = 1'b1;
      end
      if (!prev_we && we_n) begin
        if (addr !== fall_a || dq_out !== fall_d) stab_err++;
        if ((cyc - fall_cyc) < min_pw) min_pw = cyc - fall_cyc;
        if (log_n < 136) begin log_a[log_n] = addr; log_d[log_n] = dq_out; end
        log_n++;
        last_d = dq_out; rise_cyc = cyc;
        ready_cyc = (busy_len >= NEVER) ? NEVER : cyc + busy_len;
      end
      if (prev_oe && !oe_n) begin
        n_reads++;
        if (cyc < ready_cyc) begin
          tog = ~tog;
          dq_in = {~last_d[7], tog, last_d[5:0]};
        end else begin
          dq_in = last_d;
        end
      end
      if (!oe_n && (ce_n || !we_n || dq_oe)) rd_viol++;
      prev_we = we_n; prev_oe = oe_n;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) if (cyc == 190_000) begin
    n_cmp++; n_bad++;
    $display("FAIL R9 watchdog expired actual=%0d expected=<%0d", cyc, 190_000);
    summary();
  end

  task automatic run_txn(input int cnt, input logic [7:0] pg, input bit unl,
                         input bit md, input int blen);
    int exp_n, bad_idx, t_end, pulse_ok, base;
    bit done_seen, err_seen;
    logic [14:0] ea;
    logic [7:0]  ed;
    bit to;
    to = (blen >= NEVER);
    for (int i = 0; i < 128; i++) buf_mem[i] = 8'($urandom);
    log_n = 0; rd_viol = 0; stab_err = 0; min_pw = 1000; max_gap = 0;
    n_reads = 0; have_fall = 1'b0; busy_len = blen; ready_cyc = NEVER; tog = 1'b0;
    @(negedge clk);
    start = 1'b1; unlock = unl; pmode = md; page = pg; count = 8'(cnt);
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    // R11: a second request while busy must leave no trace
    start = 1'b1; page = ~pg; count = 8'd5; unlock = ~unl;
    @(negedge clk);
    start = 1'b0;
    done_seen = 0; err_seen = 0; t_end = 0;
    for (int k = 0; k < 8000; k++) begin
      @(negedge clk);
      if (done || err) begin done_seen = done; err_seen = err; t_end = cyc; break; end
    end
    @(negedge clk);
    pulse_ok = (!done && !err && !busy);
    check(pulse_ok == 1, "R9", "single-cycle end pulse / busy low", pulse_ok, 1);

    exp_n = cnt + (unl ? 3 : 0);
    check(log_n == exp_n, "R2", "write count", log_n, exp_n);
    bad_idx = -1;
    base = unl ? 3 : 0;
    for (int i = 0; i < exp_n && i < 136; i++) begin
      if (i < base) begin
        ea = (i == 1) ? 15'h2AAA : 15'h5555;
        ed = (i == 0) ? 8'hAA : (i == 1) ? 8'h55 : 8'hA0;
      end else begin
        ea = {pg, 7'(i - base)};
        ed = buf_mem[i - base];
      end
      if (bad_idx < 0 && (log_a[i] !== ea || log_d[i] !== ed)) bad_idx = i;
    end
    if (unl) check(bad_idx < 0 || bad_idx >= 3, "R3", "unlock prefix entry", bad_idx, -1);
    else     check(log_n == cnt, "R3", "no prefix without unlock", log_n, cnt);
    check(bad_idx < 0, "R2", "first wrong write index", bad_idx, -1);
    check(min_pw >= PW_MIN && stab_err == 0, "R4", "min WE width (stability errs folded)",
          (stab_err == 0) ? min_pw : -stab_err, PW_MIN);
    if (exp_n > 1) check(max_gap == BYTE_PER, "R5", "byte load spacing", max_gap, BYTE_PER);
    check(rd_viol == 0 && n_reads >= 1, "R6", "read cycle strobe violations", rd_viol, 0);

    if (to) begin
      check(err_seen && !done_seen, "R10", "timeout flag", err_seen, 1);
      check((t_end - rise_cyc) >= TMO_EXP && (t_end - rise_cyc) <= TMO_EXP + 10, "R10",
            "timeout latency", t_end - rise_cyc, TMO_EXP);
    end else begin
      check(done_seen && !err_seen, md ? "R8" : "R7", "completion seen", done_seen, 1);
      check(t_end >= ready_cyc && t_end <= ready_cyc + 60, "R9", "done vs ready cycle",
            t_end, ready_cyc);
    end
    repeat (20) @(negedge clk);
    check(log_n == exp_n && !busy, "R11", "writes after completion", log_n, exp_n);
  endtask

  initial begin
    void'($urandom(32'd7031));
    for (int i = 0; i < 128; i++) buf_mem[i] = '0;
    repeat (3) @(negedge clk);
    check(ce_n && we_n && oe_n && !dq_oe && !busy && !done && !err, "R1",
          "reset outputs", {ce_n, we_n, oe_n, dq_oe, busy, done, err}, 7'b1110000);
    rst_n = 1'b1;
    @(negedge clk);
    check(ce_n && we_n && oe_n && !busy, "R1", "idle after reset", busy, 0);

    run_txn(1,   8'h00, 1'b0, 1'b0, 25);     // R7 single byte, data poll
    run_txn(128, 8'hFF, 1'b1, 1'b1, 300);    // R8 full page with prefix, toggle
    run_txn(1,   8'h5A, 1'b1, 1'b1, 1);      // R8 ready almost at once
    run_txn(2,   8'h81, 1'b0, 1'b0, 0);      // R7 already ready at first read
    run_txn(3,   8'h10, 1'b0, 1'b0, NEVER);  // R10 data poll timeout
    run_txn(4,   8'h22, 1'b1, 1'b1, NEVER);  // R10 toggle timeout
    for (int t = 0; t < 10; t++) begin
      run_txn(int'($urandom_range(128, 1)), 8'($urandom), 1'($urandom),
              1'($urandom), int'($urandom_range(400, 5)));
    end
    summary();
  end

endmodule